// File: doc/BRIEF.md
# Peripheral Interface Control Word and Bit Set/Reset Unit

This unit is the processor-facing register slice of a three-port parallel I/O interface with ports A, B and C. It watches a chip select, a two-bit port address, a read/write select and an active-low data strobe. From these it produces port reads and register writes. It holds the write-only control register. It also keeps the output latches for the three ports, and it applies single-bit set and clear commands to port C. The handshake state machines and the pad drivers sit outside this unit. They take from it the per-port direction controls, the group mode selects, the port C ownership mask, the interrupt-enable bits and a one-cycle pulse that marks a mode load.

All logic runs on one clock. The strobe is sampled every cycle. Address, select and data are captured on each cycle the strobe is low, and a write takes effect on the first clock edge at which the strobe is seen high again. The effect therefore comes from the values present in the last low cycle. The control address takes two kinds of command, and bit 7 tells them apart. A mode command rewrites the configuration and clears every output latch. A set/reset command changes one port C latch bit and leaves the configuration alone.

Top module: `ppi_cw_unit`

## Requirements
- R1: While `rst` is high, and after it falls, both groups are in mode 0, every direction output reads input (`pa_dir_in`=1, `pb_dir_in`=1, `pc_dir_in`=8'hFF), `pc_own`=0, all three output latches are 0 and `mode_load` is 0. Reset overrides a write whose strobe rises in the same cycle.
- R2: A write is acted on only at the first clock edge where `strobe_n` is high after being low. It uses the `sel_n`, `rd_wr`, `addr` and `wdata` of the last low cycle, and it needs `sel_n`=0 and `rd_wr`=0 in that cycle. Nothing changes while the strobe stays low, and a strobe with `sel_n`=1 changes nothing.
- R3: A write to address 3 with bit 7 = 1 is a mode command. Group A mode = 2 if bit 6 is set, otherwise bit 5. Group B mode = bit 2. Port A input = bit 4, upper C input = bit 3, port B input = bit 1, lower C input = bit 0 (1 means input). In group A mode 2, `pa_dir_in` is 1.
- R4: A mode command clears the A, B and C output latches, including the interrupt-enable bits, and raises `mode_load` for exactly one cycle.
- R5: A write to address 3 with bit 7 = 0 sets port C latch bit number `wdata[3:1]` to `wdata[0]`. It ignores bits 6..4, leaves the other latch bits alone and does not change the configuration.
- R6: Writes to address 0 and address 1 load the port A and port B output latches, whatever their direction.
- R7: A write to address 2 changes only the port C latch bits that are directly writable. A bit is directly writable if it is not owned and its nibble is an output. Bits 7..4 are writable only when group A is in mode 0, and bits 3..0 whenever they are free.
- R8: `pc_own` marks the bits owned by handshake logic. Group A mode 1 with port A input owns bits 3,4,5. Group A mode 1 with port A output owns bits 3,6,7. Group A mode 2 owns bits 3..7. Group B mode 1 owns bits 0..2. Owned bits read 0 in `pc_dir_in`.
- R9: `rdata_oe` is high only while `sel_n`=0, `strobe_n`=0, `rd_wr`=1 and `addr`≠3. The control register cannot be read, and `rdata` is 0 whenever it is not driven.
- R10: A read of port A or B returns the pins when that port is an input and the latch when it is an output.
- R11: A read of port C returns `pc_hs` for owned bits, the pins for free input bits and the latch for free output bits.
- R12: The interrupt enables are latch bits: `inte_a_stb` is port C bit 4, `inte_a_ack` is bit 6 and `inte_b` is bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| addr | input | 2 | Port address: 0=A, 1=B, 2=C, 3=control |
| rd_wr | input | 1 | 1 = read, 0 = write |
| strobe_n | input | 1 | Data strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read data enable for the bus buffer |
| pa_pin | input | 8 | Port A pin values |
| pb_pin | input | 8 | Port B pin values |
| pc_pin | input | 8 | Port C pin values |
| pc_hs | input | 8 | Live handshake status for owned port C bits |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pc_out | output | 8 | Port C output latch |
| pa_dir_in | output | 1 | Port A is input |
| pb_dir_in | output | 1 | Port B is input |
| pc_dir_in | output | 8 | Per-bit input flag for free port C bits |
| pc_own | output | 8 | Port C bits owned by handshake logic |
| grp_a_mode | output | 2 | Group A mode 0..2 |
| grp_b_mode | output | 1 | Group B mode 0..1 |
| inte_a_stb | output | 1 | Group A strobe-side interrupt enable |
| inte_a_ack | output | 1 | Group A acknowledge-side interrupt enable |
| inte_b | output | 1 | Group B interrupt enable |
| mode_load | output | 1 | One-cycle pulse after a mode command |

## Verification
Two things can fall in the same cycle here. One is the completion of a write, when the strobe is seen rising. The other is a synchronous reset, or the start of the next bus access. The bench raises the strobe and `rst` at the same negative edge and expects the pure reset state afterwards. It also opens a read one cycle after a write's rising strobe and expects the read to already show the new latch value. Random mixes of mode commands, set/reset commands and port writes are compared after each access against bench functions that restate the ownership and writability rules bit by bit.

// File: rtl/ppi_cw_pkg.sv
package ppi_cw_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {ADR_A = 2'd0, ADR_B = 2'd1, ADR_C = 2'd2, ADR_CW = 2'd3} port_adr_t;

  typedef struct packed {
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_mode;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{a_mode: 2'd0, a_in: 1'b1, cu_in: 1'b1,
                                 b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  function automatic cfg_t cfg_decode(input logic [DW-1:0] w);
    cfg_t c;
    c.a_mode = w[6] ? 2'd2 : {1'b0, w[5]};
    c.a_in   = w[4];
    c.cu_in  = w[3];
    c.b_mode = w[2];
    c.b_in   = w[1];
    c.cl_in  = w[0];
    return c;
  endfunction

  function automatic logic [DW-1:0] own_mask(input cfg_t c);
    logic [DW-1:0] m;
    m = '0;
    if (c.a_mode == 2'd1)      m[7:3] = c.a_in ? 5'b00111 : 5'b11001;
    else if (c.a_mode == 2'd2) m[7:3] = 5'b11111;
    if (c.b_mode)              m[2:0] = 3'b111;
    return m;
  endfunction

  function automatic logic [DW-1:0] c_in_mask(input cfg_t c);
    return ~own_mask(c) & {{(DW/2){c.cu_in}}, {(DW/2){c.cl_in}}};
  endfunction

  function automatic logic [DW-1:0] c_direct_mask(input cfg_t c);
    logic [DW-1:0] nib;
    nib = {(c.a_mode == 2'd0) ? {(DW/2){1'b1}} : {(DW/2){1'b0}}, {(DW/2){1'b1}}};
    return ~own_mask(c) & ~c_in_mask(c) & nib;
  endfunction

  function automatic logic [DW-1:0] bit_cmd(input logic [DW-1:0] cur, input logic [DW-1:0] w);
    logic [DW-1:0] r;
    r = cur;
    r[w[3:1]] = w[0];
    return r;
  endfunction
endpackage

// File: rtl/ppi_bus_port.sv
module ppi_bus_port
  import ppi_cw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_wr,
  input  logic          strobe_n,
  input  logic [DW-1:0] wdata,
  output logic          wr_fire,
  output port_adr_t     wr_adr,
  output logic [DW-1:0] wr_data
);
  logic          strobe_q;
  logic          cap_sel_n;
  logic          cap_rd_wr;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b1;
      cap_sel_n <= 1'b1;
      cap_rd_wr <= 1'b1;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      strobe_q <= strobe_n;
      if (!strobe_n) begin
        cap_sel_n <= sel_n;
        cap_rd_wr <= rd_wr;
        cap_addr  <= addr;
        cap_data  <= wdata;
      end
    end
  end

  assign wr_fire = strobe_n & ~strobe_q & ~cap_sel_n & ~cap_rd_wr;
  assign wr_adr  = port_adr_t'(cap_addr);
  assign wr_data = cap_data;
endmodule

// File: rtl/ppi_cw_regs.sv
module ppi_cw_regs
  import ppi_cw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  port_adr_t     wr_adr,
  input  logic [DW-1:0] wr_data,
  output cfg_t          cfg,
  output logic [DW-1:0] a_lat,
  output logic [DW-1:0] b_lat,
  output logic [DW-1:0] c_lat,
  output logic          mode_load
);
  logic [DW-1:0] direct_m;
  logic          is_mode_cmd;

  assign direct_m    = c_direct_mask(cfg);
  assign is_mode_cmd = wr_fire && (wr_adr == ADR_CW) && wr_data[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= CFG_RESET;
      a_lat     <= '0;
      b_lat     <= '0;
      c_lat     <= '0;
      mode_load <= 1'b0;
    end else begin
      mode_load <= 1'b0;
      if (is_mode_cmd) begin
        cfg       <= cfg_decode(wr_data);
        a_lat     <= '0;
        b_lat     <= '0;
        c_lat     <= '0;
        mode_load <= 1'b1;
      end else if (wr_fire) begin
        case (wr_adr)
          ADR_A:   a_lat <= wr_data;
          ADR_B:   b_lat <= wr_data;
          ADR_C:   c_lat <= (c_lat & ~direct_m) | (wr_data & direct_m);
          default: c_lat <= bit_cmd(c_lat, wr_data);
        endcase
      end
    end
  end
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_cw_pkg::*;
(
  input  logic          sel_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_wr,
  input  logic          strobe_n,
  input  logic          a_in,
  input  logic          b_in,
  input  logic [DW-1:0] c_own,
  input  logic [DW-1:0] c_in,
  input  logic [DW-1:0] a_lat,
  input  logic [DW-1:0] b_lat,
  input  logic [DW-1:0] c_lat,
  input  logic [DW-1:0] pa_pin,
  input  logic [DW-1:0] pb_pin,
  input  logic [DW-1:0] pc_pin,
  input  logic [DW-1:0] pc_hs,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  logic [DW-1:0] c_view;

  always_comb begin
    for (int i = 0; i < DW; i++)
      c_view[i] = c_own[i] ? pc_hs[i] : (c_in[i] ? pc_pin[i] : c_lat[i]);
  end

  assign rdata_oe = !sel_n && !strobe_n && rd_wr && (addr != ADR_CW);

  always_comb begin
    rdata = '0;
    if (rdata_oe) begin
      case (port_adr_t'(addr))
        ADR_A:   rdata = a_in ? pa_pin : a_lat;
        ADR_B:   rdata = b_in ? pb_pin : b_lat;
        ADR_C:   rdata = c_view;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ppi_cw_unit.sv
module ppi_cw_unit
  import ppi_cw_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_wr,
  input  logic          strobe_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  input  logic [DW-1:0] pa_pin,
  input  logic [DW-1:0] pb_pin,
  input  logic [DW-1:0] pc_pin,
  input  logic [DW-1:0] pc_hs,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pc_out,
  output logic          pa_dir_in,
  output logic          pb_dir_in,
  output logic [DW-1:0] pc_dir_in,
  output logic [DW-1:0] pc_own,
  output logic [1:0]    grp_a_mode,
  output logic          grp_b_mode,
  output logic          inte_a_stb,
  output logic          inte_a_ack,
  output logic          inte_b,
  output logic          mode_load
);
  logic          wr_fire;
  port_adr_t     wr_adr;
  logic [DW-1:0] wr_data;
  cfg_t          cfg;

  ppi_bus_port u_bus (
    .clk(clk), .rst(rst), .sel_n(sel_n), .addr(addr), .rd_wr(rd_wr),
    .strobe_n(strobe_n), .wdata(wdata),
    .wr_fire(wr_fire), .wr_adr(wr_adr), .wr_data(wr_data)
  );

  ppi_cw_regs u_regs (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wr_adr(wr_adr), .wr_data(wr_data),
    .cfg(cfg), .a_lat(pa_out), .b_lat(pb_out), .c_lat(pc_out), .mode_load(mode_load)
  );

  assign pc_own     = own_mask(cfg);
  assign pc_dir_in  = c_in_mask(cfg);
  assign pa_dir_in  = (cfg.a_mode == 2'd2) ? 1'b1 : cfg.a_in;
  assign pb_dir_in  = cfg.b_in;
  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;
  assign inte_a_stb = pc_out[4];
  assign inte_a_ack = pc_out[6];
  assign inte_b     = pc_out[2];

  ppi_read_mux u_rd (
    .sel_n(sel_n), .addr(addr), .rd_wr(rd_wr), .strobe_n(strobe_n),
    .a_in(pa_dir_in), .b_in(pb_dir_in), .c_own(pc_own), .c_in(pc_dir_in),
    .a_lat(pa_out), .b_lat(pb_out), .c_lat(pc_out),
    .pa_pin(pa_pin), .pb_pin(pb_pin), .pc_pin(pc_pin), .pc_hs(pc_hs),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/ppi_cw_chk.sv
module ppi_cw_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel_n,
  input logic [1:0] addr,
  input logic       rd_wr,
  input logic       strobe_n,
  input logic [7:0] rdata,
  input logic       rdata_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic       pa_dir_in,
  input logic       pb_dir_in,
  input logic [7:0] pc_dir_in,
  input logic [7:0] pc_own,
  input logic [1:0] grp_a_mode,
  input logic       grp_b_mode,
  input logic       mode_load
);
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mode_load |-> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R4
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mode_load |=> !mode_load); // R4
  AST_OWN_NOT_INPUT: assert property (@(posedge clk) disable iff (rst)
    (pc_own & pc_dir_in) == 8'h00); // R8
  AST_NO_CW_READ: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd3 || sel_n || strobe_n) |-> !rdata_oe); // R9
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata == 8'h00)); // R9
  AST_NO_RISE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe_n, 1) && $past(strobe_n, 2)) |->
      $stable({pa_out, pb_out, pc_out, pa_dir_in, pb_dir_in, pc_dir_in, grp_a_mode, grp_b_mode})); // R2
endmodule

bind ppi_cw_unit ppi_cw_chk u_chk (.*);

// File: tb/ppi_cw_unit_bench.sv
module ppi_cw_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic       rd_wr = 1'b1;
  logic       strobe_n = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pa_pin = 8'h00, pb_pin = 8'h00, pc_pin = 8'h00, pc_hs = 8'h00;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pc_dir_in, pc_own;
  logic       rdata_oe, pa_dir_in, pb_dir_in, grp_b_mode;
  logic       inte_a_stb, inte_a_ack, inte_b, mode_load;
  logic [1:0] grp_a_mode;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] m_w, m_a, m_b, m_c;

  always #2 clk = ~clk;

  ppi_cw_unit u_ppi_cw_unit (
    .clk(clk), .rst(rst), .sel_n(sel_n), .addr(addr), .rd_wr(rd_wr), .strobe_n(strobe_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .pa_pin(pa_pin), .pb_pin(pb_pin), .pc_pin(pc_pin), .pc_hs(pc_hs),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_dir_in(pa_dir_in), .pb_dir_in(pb_dir_in), .pc_dir_in(pc_dir_in), .pc_own(pc_own),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode),
    .inte_a_stb(inte_a_stb), .inte_a_ack(inte_a_ack), .inte_b(inte_b), .mode_load(mode_load)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] f_amode(input logic [7:0] w);
    if (w[6]) return 2'd2;
    return w[5] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [7:0] f_own(input logic [7:0] w);
    logic [7:0] o = 8'h00;
    case (f_amode(w))
      2'd1: o = w[4] ? 8'h38 : 8'hC8;
      2'd2: o = 8'hF8;
      default: o = 8'h00;
    endcase
    if (w[2]) o = o | 8'h07;
    return o;
  endfunction

  function automatic logic [7:0] f_cin(input logic [7:0] w);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = !f_own(w)[i] && (i >= 4 ? w[3] : w[0]);
    return r;
  endfunction

  function automatic logic [7:0] f_cwrite(input logic [7:0] w, input logic [7:0] cur, input logic [7:0] d);
    logic [7:0] r = cur;
    for (int i = 0; i < 8; i++)
      if (!f_own(w)[i] && !(i >= 4 ? w[3] : w[0]) && (i < 4 || f_amode(w) == 2'd0)) r[i] = d[i];
    return r;
  endfunction

  function automatic logic [7:0] f_read(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'd0: r = (f_amode(m_w) == 2'd2 || m_w[4]) ? pa_pin : m_a;
      2'd1: r = m_w[1] ? pb_pin : m_b;
      default:
        for (int i = 0; i < 8; i++)
          r[i] = f_own(m_w)[i] ? pc_hs[i] : (f_cin(m_w)[i] ? pc_pin[i] : m_c[i]);
    endcase
    return r;
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = f_cwrite(m_w, m_c, d);
      default:
        if (d[7]) begin m_w = d; m_a = 0; m_b = 0; m_c = 0; end
        else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic check_state(input string req);
    chk({req, " pa_out"}, pa_out, m_a);
    chk({req, " pb_out"}, pb_out, m_b);
    chk({req, " pc_out"}, pc_out, m_c);
    chk({req, " amode"}, grp_a_mode, f_amode(m_w));
    chk({req, " bmode"}, grp_b_mode, m_w[2]);
    chk({req, " padir"}, pa_dir_in, (f_amode(m_w) == 2'd2) ? 1'b1 : m_w[4]);
    chk({req, " pbdir"}, pb_dir_in, m_w[1]);
    chk({req, " pcdir R8"}, pc_dir_in, f_cin(m_w));
    chk({req, " own R8"}, pc_own, f_own(m_w));
    chk({req, " inte R12"}, {inte_a_ack, inte_a_stb, inte_b}, {m_c[6], m_c[4], m_c[2]});
  endtask

  // write cycle: ends at the negedge after the rising strobe is seen
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic cs_n);
    @(negedge clk);
    sel_n = cs_n; addr = a; wdata = d; rd_wr = 1'b0; strobe_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    strobe_n = 1'b1;
    @(negedge clk);
    sel_n = 1'b1; rd_wr = 1'b1;
    if (!cs_n) model_write(a, d);
  endtask

  task automatic bus_read(input logic [1:0] a, input string req);
    @(negedge clk);
    sel_n = 1'b0; addr = a; rd_wr = 1'b1; strobe_n = 1'b0;
    #1;
    if (a == 2'd3) begin
      chk({req, " cw oe R9"}, rdata_oe, 1'b0);
      chk({req, " cw data R9"}, rdata, 8'h00);
    end else begin
      chk({req, " oe R9"}, rdata_oe, 1'b1);
      chk(req, rdata, f_read(a));
    end
    @(negedge clk);
    strobe_n = 1'b1; sel_n = 1'b1;
    #1;
    chk({req, " idle R9"}, {rdata_oe, rdata}, 9'h000);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'd1234));
    m_w = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    chk("R1 load", mode_load, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 after reset");

    // R6 port writes while all ports are inputs
    bus_write(2'd0, 8'hA5, 1'b0);
    bus_write(2'd1, 8'h3C, 1'b0);
    check_state("R6 latch while input");
    pa_pin = 8'h11; pb_pin = 8'h22;
    bus_read(2'd0, "R10 A pins");
    bus_read(2'd3, "R9 control");

    // R2 chip select high: no effect
    bus_write(2'd0, 8'h77, 1'b1);
    check_state("R2 sel high ignored");

    // R3/R4 mode write all outputs mode 0
    bus_write(2'd3, 8'h80, 1'b0);
    check_state("R3 mode0 out");
    chk("R4 mode_load pulse", mode_load, 1'b1);
    @(negedge clk);
    chk("R4 mode_load drop", mode_load, 1'b0);

    // R2 strobe held low: nothing changes before the rise
    @(negedge clk);
    sel_n = 0; addr = 2'd0; wdata = 8'h5A; rd_wr = 0; strobe_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 no change while low", pa_out, m_a);
    strobe_n = 1;
    @(negedge clk);
    sel_n = 1; rd_wr = 1; model_write(2'd0, 8'h5A);
    chk("R2 write on rise", pa_out, 8'h5A);

    // R5 set/reset with junk in bits 6..4
    bus_write(2'd3, 8'h75, 1'b0);
    check_state("R5 set bit2");
    chk("R5 bit2", pc_out, 8'h04);
    bus_write(2'd3, 8'h0F, 1'b0);
    chk("R5 set bit7", pc_out, 8'h84);
    bus_write(2'd3, 8'h04, 1'b0);
    chk("R5 clear bit2", pc_out, 8'h80);

    // R4 mode write clears latches
    bus_write(2'd3, 8'hB6, 1'b0);
    check_state("R4 clears in mode1");
    chk("R4 pc cleared", pc_out, 8'h00);

    // R7 direct C write in handshake mode: upper not writable
    bus_write(2'd2, 8'hFF, 1'b0);
    check_state("R7 direct C mask");

    // read immediately after a write's rising strobe
    @(negedge clk);
    sel_n = 0; addr = 2'd1; wdata = 8'hC3; rd_wr = 0; strobe_n = 0;
    repeat (2) @(negedge clk);
    strobe_n = 1;
    @(negedge clk);
    model_write(2'd1, 8'hC3);
    rd_wr = 1; strobe_n = 0;
    #1;
    chk("R10 back-to-back read", rdata, f_read(2'd1));
    @(negedge clk);
    strobe_n = 1; sel_n = 1;

    // R1 reset in the same cycle as a write rise
    @(negedge clk);
    sel_n = 0; addr = 2'd0; wdata = 8'hEE; rd_wr = 0; strobe_n = 0;
    repeat (2) @(negedge clk);
    strobe_n = 1; rst = 1;
    @(negedge clk);
    sel_n = 1; rd_wr = 1; rst = 0;
    m_w = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
    check_state("R1 reset wins");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int kind;
      logic [1:0] a;
      logic [7:0] d;
      kind = int'($urandom_range(0, 9));
      a = 2'($urandom_range(0, 3));
      d = 8'($urandom);
      pa_pin = 8'($urandom); pb_pin = 8'($urandom);
      pc_pin = 8'($urandom); pc_hs = 8'($urandom);
      if (kind < 2) begin
        d[7] = 1'b1;
        bus_write(2'd3, d, 1'b0);
        check_state("R3 random mode");
      end else if (kind < 4) begin
        d[7] = 1'b0;
        keep = m_w;
        bus_write(2'd3, d, 1'b0);
        check_state("R5 random bsr");
        chk("R5 cfg kept", f_own(m_w), f_own(keep));
      end else if (kind < 7) begin
        bus_write(a, d, 1'b0);
        check_state("R7 random write");
      end else if (kind == 7) begin
        bus_write(a, d, 1'b1);
        check_state("R2 random deselected");
      end else begin
        bus_read(a, a == 2'd2 ? "R11 C read" : "R10 read");
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule